// File: doc/BRIEF.md
# DRAM Bank Command Timing Checker

This block models a single DRAM bank as a memory controller sees it. Each cycle it may receive one command (open a row, read, write, or close the row) together with a row address. It remembers whether a row is open and which one, counts the clock cycles since the last row open, row close and column access, and decides whether the command is legal at that moment.

A legal command updates the bank state. An illegal or premature command is dropped and raises a one-cycle error pulse. Every read or write request is also classified as a row hit, a miss on an empty bank, or a conflict with a different open row. For accepted reads the block produces a data-valid strobe that starts a fixed CAS latency after the command and lasts one burst.

Top module: `dram_bank_timer`

## Requirements
- R1: After reset no row is open, and `cmd_err`, `acc_cls_valid` and `rd_valid` are low. `acc_cls` reads 0 (none).
- R2: Open-row (`cmd_op`=0) is accepted only when no row is open and at least TRP cycles have passed since the last accepted close. Once accepted, `row_open` goes high and `open_row` shows the address.
- R3: Read (`cmd_op`=1) and write (`cmd_op`=2) are accepted only when the open row equals `cmd_row` and at least TRCD cycles have passed since the accepted open.
- R4: Close (`cmd_op`=3) is accepted only when a row is open and at least TRAS cycles have passed since its open. Once accepted, `row_open` goes low. A close sent to an idle bank is rejected.
- R5: Two accepted column accesses (read or write) are at least BL cycles apart. A closer one is rejected.
- R6: A rejected command leaves `row_open`, `open_row` and the read strobe untouched. It raises `cmd_err` for exactly the one cycle after the command edge.
- R7: A read or write raises `acc_cls_valid` in the cycle after the command. In that cycle `acc_cls` is 1 for a hit, 2 when no row is open, and 3 when a different row is open. Only hits can be accepted.
- R8: An accepted read sent at clock edge E drives `rd_valid` high from edge E+CL for exactly BL cycles. Writes and rejected reads produce no strobe.
- R9: Two reads accepted exactly BL cycles apart give one unbroken strobe of 2*BL cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 open row, 1 read, 2 write, 3 close row |
| cmd_row | input | ROW_W | Row to open, or row targeted by a read or write |
| cmd_err | output | 1 | Pulse: the previous command was rejected |
| acc_cls | output | 2 | Access class: 0 none, 1 hit, 2 empty, 3 conflict |
| acc_cls_valid | output | 1 | `acc_cls` describes a read or write |
| row_open | output | 1 | A row is currently open |
| open_row | output | ROW_W | Address of the open row |
| rd_valid | output | 1 | Read data beat valid |

## Verification
The read strobe of an earlier read can still be running when a new command is checked. In one case that new command is a second read sent exactly BL cycles later. It is judged by requiring the strobe to stay high with no gap for 2*BL cycles. In the other case a write or rejected read arrives during or after a burst. The bench then counts strobe cycles over a whole CL+BL window, so an extra or missing burst shows up as a mismatch against the computed window.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } bank_op_e;

    typedef enum logic [1:0] {
        CLS_NONE     = 2'd0,
        CLS_HIT      = 2'd1,
        CLS_EMPTY    = 2'd2,
        CLS_CONFLICT = 2'd3
    } access_cls_e;
endpackage

// File: rtl/dbt_since_counter.sv
// Saturating elapsed-cycle counter: reads k at the k-th edge after a restart.
module dbt_since_counter #(
    parameter int LIMIT = 38,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] elapsed
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = W'(1);
        else if (cnt_q < LIM)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= LIM;   // all windows already satisfied after reset
        else        cnt_q <= cnt_d;
    end

    assign elapsed = cnt_q;
endmodule

// File: rtl/dbt_read_pipe.sv
// CAS-latency delay line followed by a burst-length down counter.
module dbt_read_pipe #(
    parameter int CL = 16,
    parameter int BL = 8,
    localparam int BW = $clog2(BL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic data_valid
);
    typedef struct packed {
        logic [CL-1:0] pipe;
        logic [BW-1:0] left;
    } rp_state_t;

    rp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe = CL'({st_q.pipe, launch});
        if (st_q.pipe[CL-1])
            st_d.left = BW'(BL);
        else if (st_q.left != '0)
            st_d.left = st_q.left - BW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_valid = (st_q.left != '0);

    // R8: a strobe never starts unless the delay line delivered a read
    a_r8_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(st_q.pipe[CL-1]));
endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
    import dbt_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int CL    = 16,
    parameter int TRCD  = 18,
    parameter int TRP   = 18,
    parameter int TRAS  = 38,
    parameter int BL    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    output logic             cmd_err,
    output logic [1:0]       acc_cls,
    output logic             acc_cls_valid,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rd_valid
);
    localparam int ACT_LIM = (TRAS > TRCD) ? TRAS : TRCD;
    localparam int AW = $clog2(ACT_LIM + 1);
    localparam int PW = $clog2(TRP + 1);
    localparam int CW = $clog2(BL + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic             err;
        access_cls_e      cls;
        logic             cls_vld;
    } bank_state_t;

    bank_state_t st_d, st_q;
    bank_op_e    op;
    access_cls_e cls_now;
    logic        legal, accept, is_col;
    logic        rs_act, rs_pre, rs_col, launch_rd;
    logic [AW-1:0] since_act;
    logic [PW-1:0] since_pre;
    logic [CW-1:0] since_col;

    dbt_since_counter #(.LIMIT(ACT_LIM)) u_act_cnt (
        .clk(clk), .rst_n(rst_n), .restart(rs_act), .elapsed(since_act));
    dbt_since_counter #(.LIMIT(TRP)) u_pre_cnt (
        .clk(clk), .rst_n(rst_n), .restart(rs_pre), .elapsed(since_pre));
    dbt_since_counter #(.LIMIT(BL)) u_col_cnt (
        .clk(clk), .rst_n(rst_n), .restart(rs_col), .elapsed(since_col));
    dbt_read_pipe #(.CL(CL), .BL(BL)) u_rd_pipe (
        .clk(clk), .rst_n(rst_n), .launch(launch_rd), .data_valid(rd_valid));

    always_comb begin
        op      = bank_op_e'(cmd_op);
        is_col  = (op == OP_RD) || (op == OP_WR);
        cls_now = CLS_NONE;
        legal   = 1'b0;
        case (op)
            OP_ACT: legal = !st_q.open && (since_pre >= PW'(TRP));
            OP_PRE: legal = st_q.open && (since_act >= AW'(TRAS));
            default: begin
                if (!st_q.open)             cls_now = CLS_EMPTY;
                else if (st_q.row == cmd_row) cls_now = CLS_HIT;
                else                        cls_now = CLS_CONFLICT;
                legal = (cls_now == CLS_HIT) && (since_act >= AW'(TRCD))
                        && (since_col >= CW'(BL));
            end
        endcase
        accept    = cmd_valid && legal;
        rs_act    = accept && (op == OP_ACT);
        rs_pre    = accept && (op == OP_PRE);
        rs_col    = accept && is_col;
        launch_rd = accept && (op == OP_RD);

        st_d         = st_q;
        st_d.err     = cmd_valid && !legal;
        st_d.cls_vld = cmd_valid && is_col;
        st_d.cls     = cmd_valid ? cls_now : CLS_NONE;
        if (rs_act) begin
            st_d.open = 1'b1;
            st_d.row  = cmd_row;
        end
        if (rs_pre)
            st_d.open = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{open: 1'b0, row: '0, err: 1'b0, cls: CLS_NONE, cls_vld: 1'b0};
        else        st_q <= st_d;
    end

    assign cmd_err       = st_q.err;
    assign acc_cls       = st_q.cls;
    assign acc_cls_valid = st_q.cls_vld;
    assign row_open      = st_q.open;
    assign open_row      = st_q.row;

    // R2: a row only opens on an open-row command
    a_r2_open_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_open) |-> $past(cmd_valid && cmd_op == 2'd0));
    // R4: a row only closes on a close command
    a_r4_close_needs_pre: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_open) |-> $past(cmd_valid && cmd_op == 2'd3));
    // R6: an error pulse follows a presented command and the bank state holds
    a_r6_err_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid));
    a_r6_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($stable(row_open) && $stable(open_row)));
    // R7: an accepted column access is always a hit
    a_r7_accept_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cls_valid && !cmd_err) |-> (acc_cls == 2'd1));
endmodule

// File: tb/test_dram_bank_timer.sv
module test_dram_bank_timer;
    localparam int ROW_W = 14;
    localparam int CL = 16, TRCD = 18, TRP = 18, TRAS = 38, BL = 8;

    typedef struct packed {
        logic [7:0]       gap;
        logic [1:0]       op;
        logic [ROW_W-1:0] row;
        logic             err;
        logic [1:0]       cls;
        logic             open;
        logic [ROW_W-1:0] orow;
    } vec_t;

    // gap = idle cycles before the command; timing relative to TRCD=18, TRP=18, TRAS=38, BL=8
    localparam vec_t VEC [17] = '{
        '{8'd0,  2'd1, 14'd5, 1'b1, 2'd2, 1'b0, 14'd0},  // R7 read on empty bank
        '{8'd0,  2'd3, 14'd0, 1'b1, 2'd0, 1'b0, 14'd0},  // R4 close on idle bank
        '{8'd0,  2'd0, 14'd5, 1'b0, 2'd0, 1'b1, 14'd5},  // R2 open row 5
        '{8'd16, 2'd1, 14'd5, 1'b1, 2'd1, 1'b1, 14'd5},  // R3 17 cycles < TRCD
        '{8'd0,  2'd1, 14'd5, 1'b0, 2'd1, 1'b1, 14'd5},  // R3 18 cycles ok
        '{8'd0,  2'd2, 14'd5, 1'b1, 2'd1, 1'b1, 14'd5},  // R5 column spacing 1
        '{8'd6,  2'd2, 14'd5, 1'b0, 2'd1, 1'b1, 14'd5},  // R5 column spacing 8
        '{8'd0,  2'd1, 14'd9, 1'b1, 2'd3, 1'b1, 14'd5},  // R7 conflict
        '{8'd0,  2'd0, 14'd9, 1'b1, 2'd0, 1'b1, 14'd5},  // R6 open while open, row kept
        '{8'd0,  2'd3, 14'd0, 1'b1, 2'd0, 1'b1, 14'd5},  // R4 29 cycles < TRAS
        '{8'd7,  2'd3, 14'd0, 1'b1, 2'd0, 1'b1, 14'd5},  // R4 37 cycles < TRAS
        '{8'd0,  2'd3, 14'd0, 1'b0, 2'd0, 1'b0, 14'd5},  // R4 38 cycles ok
        '{8'd0,  2'd0, 14'd9, 1'b1, 2'd0, 1'b0, 14'd5},  // R2 1 cycle < TRP
        '{8'd15, 2'd0, 14'd9, 1'b1, 2'd0, 1'b0, 14'd5},  // R2 17 cycles < TRP
        '{8'd0,  2'd0, 14'd9, 1'b0, 2'd0, 1'b1, 14'd9},  // R2 18 cycles ok
        '{8'd17, 2'd1, 14'd9, 1'b0, 2'd1, 1'b1, 14'd9},  // R3 hit accepted
        '{8'd0,  2'd2, 14'd3, 1'b1, 2'd3, 1'b1, 14'd9}   // R7 write conflict
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [ROW_W-1:0] cmd_row = '0;
    logic cmd_err, acc_cls_valid, row_open, rd_valid;
    logic [1:0] acc_cls;
    logic [ROW_W-1:0] open_row;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    dram_bank_timer #(.ROW_W(ROW_W), .CL(CL), .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .BL(BL))
        i_dram_bank_timer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
        .cmd_err(cmd_err), .acc_cls(acc_cls), .acc_cls_valid(acc_cls_valid),
        .row_open(row_open), .open_row(open_row), .rd_valid(rd_valid));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive at a negedge, command sampled at next posedge, return at the following negedge
    task automatic issue(input logic [1:0] op, input logic [ROW_W-1:0] row);
        cmd_valid = 1'b1; cmd_op = op; cmd_row = row;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // observe rd_valid at edges k = from..to after the read edge; valid expected on [lo, hi)
    task automatic watch(input string req, input int from, input int to, input int lo, input int hi);
        int bad = 0;
        for (int k = from; k <= to; k++) begin
            @(negedge clk);
            if (rd_valid != ((k >= lo) && (k < hi))) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; cmd_valid = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 row_open", int'(row_open), 0);
        check("R1 cmd_err", int'(cmd_err), 0);
        check("R1 cls_valid", int'(acc_cls_valid), 0);
        check("R1 cls", int'(acc_cls), 0);
        check("R1 rd_valid", int'(rd_valid), 0);

        foreach (VEC[i]) begin
            idle(int'(VEC[i].gap));
            issue(VEC[i].op, VEC[i].row);
            check($sformatf("R6 err vec%0d", i), int'(cmd_err), int'(VEC[i].err));
            check($sformatf("R7 cls vec%0d", i), int'(acc_cls), int'(VEC[i].cls));
            check($sformatf("R7 cls_valid vec%0d", i), int'(acc_cls_valid),
                  int'(VEC[i].op == 2'd1 || VEC[i].op == 2'd2));
            check($sformatf("R2 open vec%0d", i), int'(row_open), int'(VEC[i].open));
            if (VEC[i].open)
                check($sformatf("R2 open_row vec%0d", i), int'(open_row), int'(VEC[i].orow));
        end

        // R6: error pulse lasts one cycle
        check("R6 err pulse ends", int'(cmd_err), 1);
        @(negedge clk);
        check("R6 err pulse ends", int'(cmd_err), 0);

        // R8: single read latency and burst length
        do_reset();
        issue(2'd0, 14'd7);
        idle(TRCD - 1);
        issue(2'd1, 14'd7);
        check("R8 read accepted", int'(cmd_err), 0);
        watch("R8 strobe window", 1, CL + BL + 3, CL, CL + BL);

        // R9: reads BL apart give one unbroken 2*BL strobe
        idle(BL);
        issue(2'd1, 14'd7);
        idle(BL - 1);
        issue(2'd1, 14'd7);
        check("R9 second read accepted", int'(cmd_err), 0);
        watch("R9 merged strobe", BL + 1, CL + 2 * BL + 3, CL, CL + 2 * BL);

        // R8: write gives no strobe
        idle(BL);
        issue(2'd2, 14'd7);
        check("R8 write accepted", int'(cmd_err), 0);
        watch("R8 write no strobe", 1, CL + BL + 3, 0, 0);

        // R6: rejected read gives no strobe and keeps the row
        idle(BL);
        issue(2'd1, 14'd2);
        check("R6 rejected read err", int'(cmd_err), 1);
        watch("R6 rejected read no strobe", 1, CL + BL + 3, 0, 0);
        check("R6 row kept", int'(open_row), 7);
        check("R6 row still open", int'(row_open), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule